// File: doc/BRIEF.md
# Dual-Issue Integer Result Interlock

This block guards the decode stage of a two-way, in-order integer pipeline whose stages (fetch, decode with register read, execute, memory access, writeback) each take one cycle. Each cycle, the decode stage presents up to two instructions. Slot 0 is the older one. For each slot the block receives the source register numbers, a mask of the sources actually read, the destination register and an operation class. It returns a stall for each slot. A slot that stalls keeps its instruction in decode. A slot that issues is replaced by upstream logic.

A small ready table holds one down-counter per general register. The counter is loaded when a producer issues and counts down once per clock. A consumer is held while any source it reads has a nonzero counter. An ALU result can be used one cycle after issue, and a load result two cycles after issue. A register-to-register move in slot 0 passes its result straight to slot 1 in the same cycle, so a paired consumer of a move never waits. If slot 1 reads the destination of an ALU operation or load in slot 0 of the same pair, slot 1 is held. When slot 0 is held, slot 1 is always held as well.

Top module: `int_issue_interlock`

## Requirements
- R1: Reset clears every pending result, so after reset no source register causes a stall.
- R2: A valid slot stalls exactly while a source it reads (mask bit 0 selects source A, bit 1 selects source B) has a pending result and no forwarding applies.
- R3: An ALU operation (class 2'b01) that issues makes its destination usable in the next cycle, with no stall for a dependent instruction.
- R4: A load (class 2'b10) that issues holds a dependent instruction in the next cycle for exactly one stall cycle.
- R5: A move (class 2'b11) in slot 0 that issues forwards its destination to slot 1 in the same cycle, so slot 1 does not stall on that register. A move result is also usable in the next cycle.
- R6: Slot 1 stalls when it reads the destination of an ALU operation or load in slot 0 of the same cycle. It then waits out that producer's latency.
- R7: Whenever slot 0 is valid and stalls, a valid slot 1 stalls too.
- R8: An invalid slot never stalls. Source fields whose mask bit is clear have no effect. Class 2'b00 writes no register and leaves the ready table unchanged.
- R9: If both slots issue with the same destination, the slot 1 (younger) latency governs that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_valid | input | 1 | Slot 0 holds an instruction |
| p0_src_a | input | 4 | Slot 0 source A register |
| p0_src_b | input | 4 | Slot 0 source B register |
| p0_src_use | input | 2 | Slot 0 source read mask (bit0 A, bit1 B) |
| p0_dst | input | 4 | Slot 0 destination register |
| p0_class | input | 2 | Slot 0 class: 00 none, 01 ALU, 10 load, 11 move |
| p1_valid | input | 1 | Slot 1 holds an instruction |
| p1_src_a | input | 4 | Slot 1 source A register |
| p1_src_b | input | 4 | Slot 1 source B register |
| p1_src_use | input | 2 | Slot 1 source read mask |
| p1_dst | input | 4 | Slot 1 destination register |
| p1_class | input | 2 | Slot 1 class |
| p0_stall | output | 1 | Slot 0 held in decode |
| p1_stall | output | 1 | Slot 1 held in decode |

## Verification
Some rules can be checked on every cycle from the ports and the previous cycle. These are: an idle slot is never held, slot 1 is held whenever slot 0 is, a paired consumer of a move passes, a paired consumer of an ALU or load result is held, and a consumer one cycle behind an ALU or load producer is passed or held. Other behaviour can only be shown by the bench scenarios. These are the exact number of cycles a consumer waits, the clearing of pending results by a reset in the middle of a run, the younger slot winning on a shared destination, and masked sources or class-none producers having no effect. A bench model of the countdown table checks every cycle of a long random instruction stream.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;
    typedef enum logic [1:0] {
        OPC_NONE = 2'b00,
        OPC_ALU  = 2'b01,
        OPC_LOAD = 2'b10,
        OPC_MOVE = 2'b11
    } op_class_e;
endpackage

// File: rtl/ilk_ready_table.sv
`timescale 1ns/1ps
// Per-register result countdown; younger writer wins on same index.
module ilk_ready_table #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4,
    parameter int CNT_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr0_en,
    input  logic [REG_W-1:0]    wr0_idx,
    input  logic [CNT_W-1:0]    wr0_cnt,
    input  logic                wr1_en,
    input  logic [REG_W-1:0]    wr1_idx,
    input  logic [CNT_W-1:0]    wr1_cnt,
    output logic [NUM_REGS-1:0] busy
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (wr1_en && wr1_idx == REG_W'(g))
                cnt <= wr1_cnt;
            else if (wr0_en && wr0_idx == REG_W'(g))
                cnt <= wr0_cnt;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
        assign busy[g] = (cnt != '0);
    end
endmodule

// File: rtl/ilk_src_check.sv
`timescale 1ns/1ps
// Source readiness test for one slot, with optional same-cycle bypass.
module ilk_src_check #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4
) (
    input  logic [NUM_REGS-1:0] busy,
    input  logic [REG_W-1:0]    src_a,
    input  logic [REG_W-1:0]    src_b,
    input  logic [1:0]          src_use,
    input  logic                fwd_en,
    input  logic [REG_W-1:0]    fwd_idx,
    output logic                hazard
);
    logic pend_a, pend_b;
    always_comb begin
        pend_a = src_use[0] && busy[src_a] && !(fwd_en && fwd_idx == src_a);
        pend_b = src_use[1] && busy[src_b] && !(fwd_en && fwd_idx == src_b);
        hazard = pend_a || pend_b;
    end
endmodule

// File: rtl/ilk_pair_check.sv
`timescale 1ns/1ps
// Slot 1 reading a non-forwardable result of slot 0 in the same pair.
module ilk_pair_check #(
    parameter int REG_W = 4
) (
    input  logic                 old_valid,
    input  ilk_pkg::op_class_e   old_class,
    input  logic [REG_W-1:0]     old_dst,
    input  logic [REG_W-1:0]     src_a,
    input  logic [REG_W-1:0]     src_b,
    input  logic [1:0]           src_use,
    output logic                 hazard
);
    import ilk_pkg::*;
    logic slow_prod;
    always_comb begin
        slow_prod = old_valid && (old_class == OPC_ALU || old_class == OPC_LOAD);
        hazard = slow_prod && ((src_use[0] && src_a == old_dst) ||
                               (src_use[1] && src_b == old_dst));
    end
endmodule

// File: rtl/int_issue_interlock.sv
`timescale 1ns/1ps
module int_issue_interlock #(
    parameter int NUM_REGS = 16,
    parameter int ALU_LAT  = 1,
    parameter int LOAD_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       p0_valid,
    input  logic [3:0] p0_src_a,
    input  logic [3:0] p0_src_b,
    input  logic [1:0] p0_src_use,
    input  logic [3:0] p0_dst,
    input  logic [1:0] p0_class,
    input  logic       p1_valid,
    input  logic [3:0] p1_src_a,
    input  logic [3:0] p1_src_b,
    input  logic [1:0] p1_src_use,
    input  logic [3:0] p1_dst,
    input  logic [1:0] p1_class,
    output logic       p0_stall,
    output logic       p1_stall
);
    import ilk_pkg::*;

    localparam int REG_W   = $clog2(NUM_REGS);
    localparam int MAX_LAT = (LOAD_LAT > ALU_LAT) ? LOAD_LAT : ALU_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    function automatic logic [CNT_W-1:0] wait_for(input op_class_e c);
        unique case (c)
            OPC_ALU:  wait_for = CNT_W'(ALU_LAT - 1);
            OPC_LOAD: wait_for = CNT_W'(LOAD_LAT - 1);
            default:  wait_for = '0;
        endcase
    endfunction

    op_class_e         cls0, cls1;
    logic [NUM_REGS-1:0] busy;
    logic              hz0, hz1, pair_hz, fwd_en;
    logic              wr0_en, wr1_en;

    assign cls0   = op_class_e'(p0_class);
    assign cls1   = op_class_e'(p1_class);
    assign fwd_en = p0_valid && (cls0 == OPC_MOVE);

    ilk_src_check #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_src0 (
        .busy(busy), .src_a(p0_src_a[REG_W-1:0]), .src_b(p0_src_b[REG_W-1:0]),
        .src_use(p0_src_use), .fwd_en(1'b0), .fwd_idx('0), .hazard(hz0)
    );

    ilk_src_check #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_src1 (
        .busy(busy), .src_a(p1_src_a[REG_W-1:0]), .src_b(p1_src_b[REG_W-1:0]),
        .src_use(p1_src_use), .fwd_en(fwd_en), .fwd_idx(p0_dst[REG_W-1:0]),
        .hazard(hz1)
    );

    ilk_pair_check #(.REG_W(REG_W)) u_pair (
        .old_valid(p0_valid), .old_class(cls0), .old_dst(p0_dst[REG_W-1:0]),
        .src_a(p1_src_a[REG_W-1:0]), .src_b(p1_src_b[REG_W-1:0]),
        .src_use(p1_src_use), .hazard(pair_hz)
    );

    always_comb begin
        p0_stall = p0_valid && hz0;
        p1_stall = p1_valid && (p0_stall || hz1 || pair_hz);
        wr0_en   = p0_valid && !p0_stall && (cls0 != OPC_NONE);
        wr1_en   = p1_valid && !p1_stall && (cls1 != OPC_NONE);
    end

    ilk_ready_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr0_en(wr0_en), .wr0_idx(p0_dst[REG_W-1:0]), .wr0_cnt(wait_for(cls0)),
        .wr1_en(wr1_en), .wr1_idx(p1_dst[REG_W-1:0]), .wr1_cnt(wait_for(cls1)),
        .busy(busy)
    );
endmodule

// File: rtl/int_issue_interlock_chk.sv
`timescale 1ns/1ps
module int_issue_interlock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       p0_valid,
    input logic [3:0] p0_src_a,
    input logic [3:0] p0_src_b,
    input logic [1:0] p0_src_use,
    input logic [3:0] p0_dst,
    input logic [1:0] p0_class,
    input logic       p1_valid,
    input logic [3:0] p1_src_a,
    input logic [3:0] p1_src_b,
    input logic [1:0] p1_src_use,
    input logic [3:0] p1_dst,
    input logic [1:0] p1_class,
    input logic       p0_stall,
    input logic       p1_stall
);
    logic past_ok;
    logic iss0, iss1;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end
    assign iss0 = p0_valid && !p0_stall && (p0_class != 2'b00);
    assign iss1 = p1_valid && !p1_stall && (p1_class != 2'b00);

    a_r8_idle0: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_valid |-> !p0_stall);
    a_r8_idle1: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_valid |-> !p1_stall);
    a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_valid && p0_stall && p1_valid) |-> p1_stall);
    a_r5_move_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_valid && !p0_stall && p0_class == 2'b11 && p1_valid &&
         p1_src_use == 2'b01 && p1_src_a == p0_dst) |-> !p1_stall);
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_valid && (p0_class == 2'b01 || p0_class == 2'b10) && p1_valid &&
         p1_src_use[0] && p1_src_a == p0_dst) |-> p1_stall);
    a_r4_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(iss0 && p0_class == 2'b10 && !(iss1 && p1_dst == p0_dst)) &&
         p0_valid && p0_src_use[0] && p0_src_a == $past(p0_dst)) |-> p0_stall);
    a_r3_alu_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(iss0 && p0_class == 2'b01 && !(iss1 && p1_dst == p0_dst)) &&
         p0_valid && p0_src_use == 2'b01 && p0_src_a == $past(p0_dst)) |-> !p0_stall);
endmodule

bind int_issue_interlock int_issue_interlock_chk u_chk (.*);

// File: tb/int_issue_interlock_bench.sv
`timescale 1ns/1ps
module int_issue_interlock_bench;
    localparam realtime CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p0_valid = 0, p1_valid = 0;
    logic [3:0] p0_src_a = 0, p0_src_b = 0, p0_dst = 0;
    logic [3:0] p1_src_a = 0, p1_src_b = 0, p1_dst = 0;
    logic [1:0] p0_src_use = 0, p0_class = 0, p1_src_use = 0, p1_class = 0;
    logic p0_stall, p1_stall;

    always #(CLK_P/2) clk = ~clk;

    int_issue_interlock u_int_issue_interlock (.*);

    int checks = 0;
    int failures = 0;
    int cnt_m [16];
    bit sv [2];
    int sa [2], sb [2], su [2], sd [2], sc [2];

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic int wait_of(input int c);
        return (c == 2) ? 1 : 0;
    endfunction

    function automatic bit pend(input int r, input int use_bit, input bit fe, input int fr);
        return use_bit != 0 && cnt_m[r] > 0 && !(fe && fr == r);
    endfunction

    task automatic set_slot(input int p, input int a, input int b, input int u,
                            input int d, input int c);
        sv[p] = 1; sa[p] = a; sb[p] = b; su[p] = u; sd[p] = d; sc[p] = c;
    endtask

    task automatic step();
        bit e0, e1, fe, i0, i1;
        @(negedge clk);
        p0_valid = sv[0]; p0_src_a = 4'(sa[0]); p0_src_b = 4'(sb[0]);
        p0_src_use = 2'(su[0]); p0_dst = 4'(sd[0]); p0_class = 2'(sc[0]);
        p1_valid = sv[1]; p1_src_a = 4'(sa[1]); p1_src_b = 4'(sb[1]);
        p1_src_use = 2'(su[1]); p1_dst = 4'(sd[1]); p1_class = 2'(sc[1]);
        #2;
        e0 = sv[0] && (pend(sa[0], su[0] & 1, 0, 0) || pend(sb[0], su[0] & 2, 0, 0));
        fe = sv[0] && sc[0] == 3;
        e1 = sv[1] && (e0 || pend(sa[1], su[1] & 1, fe, sd[0]) ||
                       pend(sb[1], su[1] & 2, fe, sd[0]) ||
                       (sv[0] && (sc[0] == 1 || sc[0] == 2) &&
                        (((su[1] & 1) != 0 && sa[1] == sd[0]) ||
                         ((su[1] & 2) != 0 && sb[1] == sd[0]))));
        check(p0_stall, e0, "R2 slot0 stall");
        check(p1_stall, e1, e0 && sv[1] ? "R7 slot1 follows slot0" : "R2 slot1 stall");
        for (int r = 0; r < 16; r++) if (cnt_m[r] > 0) cnt_m[r]--;
        i0 = sv[0] && !e0;
        i1 = sv[1] && !e1;
        if (i0 && sc[0] != 0) cnt_m[sd[0]] = wait_of(sc[0]);
        if (i1 && sc[1] != 0) cnt_m[sd[1]] = wait_of(sc[1]);
        if (i0) sv[0] = 0;
        if (i1) sv[1] = 0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while ((sv[0] || sv[1]) && n < 50) begin
            step();
            n++;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        sv[0] = 0; sv[1] = 0;
        p0_valid = 0; p1_valid = 0;
        for (int r = 0; r < 16; r++) cnt_m[r] = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(p0_stall, 1'b0, "R1 reset slot0");
            check(p1_stall, 1'b0, "R1 reset slot1");
        end
        rst_n = 1;
    endtask

    task automatic expect_n(input int n, input int exp, input string tag);
        checks++;
        if (n != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, n, exp);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20250611));
        for (int r = 0; r < 16; r++) cnt_m[r] = 0;
        sv[0] = 0; sv[1] = 0;
        do_reset();

        // R4: load then dependent
        set_slot(0, 0, 0, 0, 3, 2); drain(n);
        set_slot(0, 3, 0, 1, 9, 1); drain(n); expect_n(n, 2, "R4 load wait");
        idle(3);
        // R3: ALU then dependent
        set_slot(0, 0, 0, 0, 4, 1); drain(n);
        set_slot(0, 4, 0, 1, 9, 1); drain(n); expect_n(n, 1, "R3 alu no wait");
        idle(3);
        // R5: paired move forwarding
        set_slot(0, 1, 0, 1, 6, 3); set_slot(1, 6, 0, 1, 10, 1);
        drain(n); expect_n(n, 1, "R5 move bypass");
        idle(3);
        // R6: paired ALU / load producer
        set_slot(0, 0, 0, 0, 7, 1); set_slot(1, 7, 0, 1, 10, 1);
        drain(n); expect_n(n, 2, "R6 pair alu");
        idle(3);
        set_slot(0, 0, 0, 0, 7, 2); set_slot(1, 0, 7, 2, 10, 1);
        drain(n); expect_n(n, 3, "R6 pair load");
        idle(3);
        // R7: slot0 held holds slot1
        set_slot(0, 0, 0, 0, 8, 2); drain(n);
        set_slot(0, 8, 0, 1, 9, 1); set_slot(1, 13, 0, 1, 10, 1);
        drain(n); expect_n(n, 2, "R7 in-order hold");
        idle(3);
        // R8: masked sources and class none
        set_slot(0, 0, 0, 0, 2, 2); drain(n);
        set_slot(0, 2, 2, 0, 9, 1); drain(n); expect_n(n, 1, "R8 no sources");
        set_slot(0, 0, 0, 0, 2, 2); drain(n);
        set_slot(0, 2, 0, 2, 9, 1); drain(n); expect_n(n, 1, "R8 masked src a");
        idle(3);
        set_slot(0, 0, 0, 0, 11, 0); drain(n);
        set_slot(0, 11, 0, 1, 9, 1); drain(n); expect_n(n, 1, "R8 class none");
        idle(3);
        // R9: younger writer governs
        set_slot(0, 0, 0, 0, 5, 1); set_slot(1, 0, 0, 0, 5, 2); drain(n);
        set_slot(0, 5, 0, 1, 9, 1); drain(n); expect_n(n, 2, "R9 younger load");
        idle(3);
        set_slot(0, 0, 0, 0, 5, 2); set_slot(1, 0, 0, 0, 5, 1); drain(n);
        set_slot(0, 5, 0, 1, 9, 1); drain(n); expect_n(n, 1, "R9 younger alu");
        idle(3);
        // R1: reset drops a pending load
        set_slot(0, 0, 0, 0, 12, 2); step();
        do_reset();
        set_slot(0, 12, 0, 1, 9, 1); drain(n); expect_n(n, 1, "R1 reset clears");

        // random stream over a few registers
        for (int i = 0; i < 6000; i++) begin
            if (!sv[0] && !sv[1]) begin
                for (int p = 0; p < 2; p++) begin
                    set_slot(p, $urandom_range(0, 5), $urandom_range(0, 5),
                             $urandom_range(0, 3), $urandom_range(0, 5),
                             $urandom_range(0, 3));
                    if ($urandom_range(0, 7) == 0) sv[p] = 0;
                end
            end
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule